// File: doc/BRIEF.md
# Encryption Exclusion Range Matcher

This block decides, for every memory request, whether the request falls inside the single physical-address window for which memory encryption is skipped. It holds a mask register and a base register that software programs through a simple write port. Each write is validated before it is committed. A write that is malformed, or that arrives after the activation lock has been set, is rejected and reported on a fault pulse.

Each incoming platform address carries a key identifier in its topmost bits. The number of those bits comes from a runtime input, and the platform address width is a parameter. The block separates the key identifier from the real address. A request is marked excluded only when its key identifier is zero, the window is enabled, and the real address agrees with the base on every position the mask selects. The result, the key identifier and the stripped address are all registered, so they appear one cycle after the request. The lock register itself and any cipher datapath are outside the block; the lock arrives as an input.

Top module: `excl_range_match`

## Requirements
- R1: After reset, rsp_valid_o and wr_fault_o are low and the window is disabled, so no request is reported as excluded until a valid mask write sets the enable bit.
- R2: With k = min(kid_bits_i, KID_MAX), the key identifier is address bits [PA_W-1 : PA_W-k], zero-extended, and is zero when k = 0. The stripped address equals the input address with those k top bits cleared.
- R3: rsp_valid_o is high in exactly the cycle after a cycle with req_valid_i high. rsp_keyid_o and rsp_addr_o belong to that request.
- R4: A response is excluded exactly when its key identifier is 0, the stored enable bit is 1, and (addr[PA_W-1:12] XOR base[PA_W-1:12]) AND mask[PA_W-1:12] is zero.
- R5: A request with a non-zero key identifier is never excluded, whatever the window settings are.
- R6: wr_sel_i = 0 selects the mask register and wr_sel_i = 1 selects the base register. In the mask register, bit 11 is the enable and bits PA_W-1:12 are the match field; bits 10:0 are ignored. In the base register, bits PA_W-1:12 are the field and bits 11:0 are ignored. An accepted write applies to requests issued in the cycles after it.
- R7: A write that has any bit at or above PA_W set is rejected, and both registers keep their values.
- R8: A mask write is rejected, with both registers unchanged, when its field bits PA_W-1:12 are not a run of ones starting at bit PA_W-1 followed only by zeros. An all-zero field counts as valid.
- R9: While lock_i is high, every write to either register is rejected and both registers keep their values. Classification of requests is not affected by the lock.
- R10: wr_fault_o pulses high for one cycle, in the cycle after a rejected write. It stays low after an accepted write and in any cycle not preceded by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Activation lock; when high, all writes are rejected |
| kid_bits_i | input | KB_W | Number of key-identifier bits in use (saturates at KID_MAX) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = mask register, 1 = base register |
| wr_data_i | input | 64 | Write data |
| wr_fault_o | output | 1 | Rejected-write pulse, one cycle after the write |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | PA_W | Platform address, with the key identifier in its top bits |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_excluded_o | output | 1 | Request lies in the unencrypted window |
| rsp_keyid_o | output | KID_MAX | Extracted key identifier |
| rsp_addr_o | output | PA_W | Address with the key-identifier bits cleared |

## Verification
The bench writes every possible 8-bit mask field. A design with a wrong contiguity test would accept a field with a hole, or reject a legal one such as all-zero or all-one, and the fault flag would disagree with the model. For each legal mask depth, the bench flips each address bit in turn around the programmed base. If the mask were applied inverted, or to the wrong bit range, the excluded flag would be reported on the wrong side of that flip. The key-identifier width is swept through zero, mid and saturating values, which exposes an off-by-one in the split or a non-zero key that is wrongly matched. Finally, the bench issues writes that are locked, that carry bits above the address width, or that set only reserved low bits, and then probes with requests. A design that commits a rejected write, or that faults on reserved bits, shows up as a wrong classification.

// File: rtl/excl_range_pkg.sv
package excl_range_pkg;
  localparam int unsigned REG_W     = 64;
  localparam int unsigned FIELD_LSB = 12;
  localparam int unsigned EN_BIT    = 11;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_BASE = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/excl_rst_sync.sv
module excl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/excl_cfg_regs.sv
module excl_cfg_regs
  import excl_range_pkg::*;
#(
  parameter int unsigned PA_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lock_i,
  input  logic                      wr_en_i,
  input  logic                      wr_sel_i,
  input  logic [REG_W-1:0]          wr_data_i,
  output logic                      wr_fault_o,
  output logic                      range_en_o,
  output logic [PA_W-FIELD_LSB-1:0] mask_fld_o,
  output logic [PA_W-FIELD_LSB-1:0] base_fld_o
);
  localparam int unsigned FLD_W = PA_W - FIELD_LSB;

  logic [FLD_W-1:0] wr_fld;
  logic [FLD_W-1:0] fld_inv;
  logic [FLD_W-1:0] fld_inv_inc;
  logic [REG_W-1:0] hi_part;
  logic             hi_bad;
  logic             fld_contig;
  logic             is_mask;
  logic             fault_d;
  logic             accept;

  logic             en_d,   en_q;
  logic [FLD_W-1:0] mask_d, mask_q;
  logic [FLD_W-1:0] base_d, base_q;
  logic             fault_q;

  logic unused_lo;
  assign unused_lo = ^wr_data_i[EN_BIT-1:0];

  // Write validation
  always_comb begin
    wr_fld      = wr_data_i[PA_W-1:FIELD_LSB];
    hi_part     = wr_data_i >> PA_W;
    hi_bad      = |hi_part;
    fld_inv     = ~wr_fld;
    fld_inv_inc = fld_inv + 1'b1;
    // inverted field must be a run of ones from bit 0 upward
    fld_contig  = ((fld_inv & fld_inv_inc) == '0);
    is_mask     = (cfg_sel_e'(wr_sel_i) == SEL_MASK);
    fault_d     = wr_en_i & (lock_i | hi_bad | (is_mask & ~fld_contig));
    accept      = wr_en_i & ~fault_d;
  end

  // Next state
  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    base_d = base_q;
    if (accept) begin
      if (is_mask) begin
        en_d   = wr_data_i[EN_BIT];
        mask_d = wr_fld;
      end else begin
        base_d = wr_fld;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
    end else if (accept) begin
      en_q   <= en_d;
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign wr_fault_o = fault_q;
  assign range_en_o = en_q;
  assign mask_fld_o = mask_q;
  assign base_fld_o = base_q;
endmodule

// File: rtl/excl_addr_split.sv
module excl_addr_split #(
  parameter int unsigned PA_W    = 20,
  parameter int unsigned KID_MAX = 4,
  parameter int unsigned KB_W    = 3
) (
  input  logic [KB_W-1:0]    kid_bits_i,
  input  logic [PA_W-1:0]    addr_i,
  output logic [KID_MAX-1:0] keyid_o,
  output logic [PA_W-1:0]    phys_o
);
  localparam int unsigned PA_CW = $clog2(PA_W + 1);

  logic [KB_W-1:0]    kid_eff;
  logic [PA_CW-1:0]   phys_w;
  logic [PA_W-1:0]    keep;
  logic [KID_MAX-1:0] kid_keep;
  logic [PA_W-1:0]    shifted;

  always_comb begin
    kid_eff = (kid_bits_i > KB_W'(KID_MAX)) ? KB_W'(KID_MAX) : kid_bits_i;
    phys_w  = PA_CW'(PA_W) - PA_CW'(kid_eff);
    shifted = addr_i >> phys_w;
  end

  for (genvar i = 0; i < PA_W; i++) begin : g_keep
    assign keep[i] = (PA_CW'(i) < phys_w);
  end

  for (genvar j = 0; j < KID_MAX; j++) begin : g_kid
    assign kid_keep[j] = (KB_W'(j) < kid_eff);
  end

  assign keyid_o = shifted[KID_MAX-1:0] & kid_keep;
  assign phys_o  = addr_i & keep;
endmodule

// File: rtl/excl_classify.sv
module excl_classify
  import excl_range_pkg::*;
#(
  parameter int unsigned PA_W    = 20,
  parameter int unsigned KID_MAX = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  input  logic [KID_MAX-1:0]        keyid_i,
  input  logic [PA_W-1:0]           phys_i,
  input  logic                      range_en_i,
  input  logic [PA_W-FIELD_LSB-1:0] mask_fld_i,
  input  logic [PA_W-FIELD_LSB-1:0] base_fld_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_excluded_o,
  output logic [KID_MAX-1:0]        rsp_keyid_o,
  output logic [PA_W-1:0]           rsp_addr_o
);
  localparam int unsigned FLD_W = PA_W - FIELD_LSB;

  logic [FLD_W-1:0] diff;
  logic             hit;
  logic             excl_d;

  logic               valid_q;
  logic               excl_q;
  logic [KID_MAX-1:0] kid_q;
  logic [PA_W-1:0]    addr_q;

  always_comb begin
    diff   = (phys_i[PA_W-1:FIELD_LSB] ^ base_fld_i) & mask_fld_i;
    hit    = (diff == '0);
    excl_d = req_valid_i & range_en_i & (keyid_i == '0) & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      excl_q  <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      excl_q  <= excl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kid_q  <= '0;
      addr_q <= '0;
    end else if (req_valid_i) begin
      kid_q  <= keyid_i;
      addr_q <= phys_i;
    end
  end

  assign rsp_valid_o    = valid_q;
  assign rsp_excluded_o = excl_q;
  assign rsp_keyid_o    = kid_q;
  assign rsp_addr_o     = addr_q;
endmodule

// File: rtl/excl_range_match.sv
module excl_range_match
  import excl_range_pkg::*;
#(
  parameter int unsigned PA_W    = 20,
  parameter int unsigned KID_MAX = 4,
  parameter int unsigned KB_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_i,
  input  logic [KB_W-1:0]    kid_bits_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [63:0]        wr_data_i,
  output logic               wr_fault_o,
  input  logic               req_valid_i,
  input  logic [PA_W-1:0]    req_addr_i,
  output logic               rsp_valid_o,
  output logic               rsp_excluded_o,
  output logic [KID_MAX-1:0] rsp_keyid_o,
  output logic [PA_W-1:0]    rsp_addr_o
);
  localparam int unsigned FLD_W = PA_W - FIELD_LSB;

  logic               rst_n_q;
  logic               cfg_en;
  logic [FLD_W-1:0]   cfg_mask;
  logic [FLD_W-1:0]   cfg_base;
  logic [KID_MAX-1:0] req_kid;
  logic [PA_W-1:0]    req_phys;

  excl_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_q)
  );

  excl_cfg_regs #(.PA_W(PA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .lock_i     (lock_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .wr_fault_o (wr_fault_o),
    .range_en_o (cfg_en),
    .mask_fld_o (cfg_mask),
    .base_fld_o (cfg_base)
  );

  excl_addr_split #(.PA_W(PA_W), .KID_MAX(KID_MAX), .KB_W(KB_W)) u_split (
    .kid_bits_i (kid_bits_i),
    .addr_i     (req_addr_i),
    .keyid_o    (req_kid),
    .phys_o     (req_phys)
  );

  excl_classify #(.PA_W(PA_W), .KID_MAX(KID_MAX)) u_cls (
    .clk            (clk),
    .rst_n          (rst_n_q),
    .req_valid_i    (req_valid_i),
    .keyid_i        (req_kid),
    .phys_i         (req_phys),
    .range_en_i     (cfg_en),
    .mask_fld_i     (cfg_mask),
    .base_fld_i     (cfg_base),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_excluded_o (rsp_excluded_o),
    .rsp_keyid_o    (rsp_keyid_o),
    .rsp_addr_o     (rsp_addr_o)
  );
endmodule

// File: rtl/excl_range_match_chk.sv
module excl_range_match_chk #(
  parameter int unsigned PA_W    = 20,
  parameter int unsigned KID_MAX = 4,
  parameter int unsigned FLD_W   = 8
) (
  input logic               clk,
  input logic               rst_n_q,
  input logic               lock_i,
  input logic               wr_en_i,
  input logic               wr_fault_o,
  input logic               req_valid_i,
  input logic               rsp_valid_o,
  input logic               rsp_excluded_o,
  input logic [KID_MAX-1:0] rsp_keyid_o,
  input logic               cfg_en,
  input logic [FLD_W-1:0]   cfg_mask,
  input logic [FLD_W-1:0]   cfg_base
);
  // R9: a write under lock is answered by a fault pulse
  p_lock_faults_r9: assert property (@(posedge clk) disable iff (!rst_n_q)
    (wr_en_i && lock_i) |=> wr_fault_o);

  // R7: a reported fault means the registers kept their values
  p_fault_keeps_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n_q)
    wr_fault_o |-> ($stable(cfg_mask) && $stable(cfg_base) && $stable(cfg_en)));

  // R10: no write, no fault
  p_no_spurious_fault_r10: assert property (@(posedge clk) disable iff (!rst_n_q)
    !wr_en_i |=> !wr_fault_o);

  // R3: response strobe follows request strobe by one cycle
  p_rsp_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_wo_req_r3: assert property (@(posedge clk) disable iff (!rst_n_q)
    !req_valid_i |=> !rsp_valid_o);

  // R5: exclusion only for key zero on a valid response
  p_excl_key_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_q)
    rsp_excluded_o |-> (rsp_valid_o && (rsp_keyid_o == '0)));

  // R8: stored mask never has a one directly below a zero
  p_mask_contig_r8: assert property (@(posedge clk) disable iff (!rst_n_q)
    ((FLD_W'(cfg_mask << 1)) & ~cfg_mask) == '0);
endmodule

bind excl_range_match excl_range_match_chk #(
  .PA_W(PA_W), .KID_MAX(KID_MAX), .FLD_W(PA_W - 12)
) i_chk (
  .clk            (clk),
  .rst_n_q        (rst_n_q),
  .lock_i         (lock_i),
  .wr_en_i        (wr_en_i),
  .wr_fault_o     (wr_fault_o),
  .req_valid_i    (req_valid_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_excluded_o (rsp_excluded_o),
  .rsp_keyid_o    (rsp_keyid_o),
  .cfg_en         (cfg_en),
  .cfg_mask       (cfg_mask),
  .cfg_base       (cfg_base)
);

// File: tb/test_excl_range_match.sv
`timescale 1ns/1ps
module test_excl_range_match;
  localparam int PA_W    = 20;
  localparam int KID_MAX = 4;
  localparam int KB_W    = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               lock_i = 1'b0;
  logic [KB_W-1:0]    kid_bits_i = '0;
  logic               wr_en_i = 1'b0;
  logic               wr_sel_i = 1'b0;
  logic [63:0]        wr_data_i = '0;
  logic               wr_fault_o;
  logic               req_valid_i = 1'b0;
  logic [PA_W-1:0]    req_addr_i = '0;
  logic               rsp_valid_o;
  logic               rsp_excluded_o;
  logic [KID_MAX-1:0] rsp_keyid_o;
  logic [PA_W-1:0]    rsp_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the configuration
  bit       m_en = 0;
  int       m_mask = 0;
  int       m_base = 0;

  always #2.5 clk = ~clk;

  excl_range_match #(.PA_W(PA_W), .KID_MAX(KID_MAX), .KB_W(KB_W)) i_excl_range_match (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .kid_bits_i(kid_bits_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .wr_fault_o(wr_fault_o), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_excluded_o(rsp_excluded_o),
    .rsp_keyid_o(rsp_keyid_o), .rsp_addr_o(rsp_addr_o)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit contig8(input int m);
    bit seen_zero = 0;
    bit ok = 1;
    for (int i = 7; i >= 0; i--) begin
      if (((m >> i) & 1) == 0) seen_zero = 1;
      else if (seen_zero) ok = 0;
    end
    return ok;
  endfunction

  // starts and ends at a falling edge
  task automatic do_write(input bit sel, input logic [63:0] data, input string req);
    bit exp_fault;
    exp_fault = lock_i || ((data >> PA_W) != 0) ||
                (sel == 1'b0 && !contig8(int'(data[19:12])));
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    check(req, "write fault", wr_fault_o, exp_fault);
    wr_en_i = 1'b0;
    if (!exp_fault) begin
      if (sel == 1'b0) begin m_en = data[11]; m_mask = int'(data[19:12]); end
      else m_base = int'(data[19:12]);
    end
    @(negedge clk);
    check("R10", "fault after idle", wr_fault_o, 0);
  endtask

  task automatic do_req(input int a, input string req);
    int keff, pw, ek, ea;
    bit ex;
    keff = (int'(kid_bits_i) > KID_MAX) ? KID_MAX : int'(kid_bits_i);
    pw = PA_W - keff;
    ek = (keff == 0) ? 0 : (a >> pw);
    ea = a & ((1 << pw) - 1);
    ex = m_en && (ek == 0) && ((((ea >> 12) ^ m_base) & m_mask) == 0);
    req_valid_i = 1'b1; req_addr_i = a[PA_W-1:0];
    @(negedge clk);
    check("R3", "rsp valid", rsp_valid_o, 1);
    check("R2", "keyid", rsp_keyid_o, ek);
    check("R2", "stripped addr", rsp_addr_o, ea);
    check(req, "excluded", rsp_excluded_o, ex);
    req_valid_i = 1'b0;
    @(negedge clk);
    check("R3", "rsp valid idle", rsp_valid_o, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "rsp valid", rsp_valid_o, 0);
    check("R1", "fault", wr_fault_o, 0);
    do_req(0, "R1");

    // R2 split sweep with window disabled
    for (int k = 0; k < 8; k++) begin
      kid_bits_i = KB_W'(k);
      for (int t = 0; t < 8; t++) do_req((t * 32'h2D6B9 + k * 32'h51) & 32'hFFFFF, "R2");
    end

    // R8 every mask field value, enable set
    kid_bits_i = 3'd2;
    for (int f = 0; f < 256; f++) begin
      do_write(1'b0, 64'(f) << 12 | 64'h800, "R8");
      do_req(32'h0A000, "R8");
    end

    // R4/R5 contiguous depths, bases, key widths, single bit flips
    for (int n = 0; n <= 8; n++) begin
      do_write(1'b0, (64'((32'hFF << (8 - n)) & 32'hFF) << 12) | 64'h800, "R6");
      for (int b = 0; b < 3; b++) begin
        do_write(1'b1, 64'((b == 0) ? 32'h00 : (b == 1) ? 32'h0A : 32'h03) << 12, "R6");
        for (int kk = 0; kk < 3; kk++) begin
          kid_bits_i = KB_W'((kk == 0) ? 0 : (kk == 1) ? 2 : 5);
          for (int t = 0; t <= 16; t++) begin
            int a;
            a = (m_base << 12) ^ ((t < 16) ? (1 << (t + 4)) : 0);
            do_req(a & 32'hFFFFF, (a >= (1 << 16)) ? "R5" : "R4");
          end
        end
      end
    end

    // R6 reserved low bits ignored
    kid_bits_i = 3'd1;
    do_write(1'b0, 64'hF0FFF, "R6");
    do_write(1'b1, 64'h50FFF, "R6");
    do_req(32'h5F123, "R6");
    do_req(32'h4F123, "R6");

    // R7 bits at or above the address width
    do_write(1'b0, 64'h1FF800, "R7");
    do_write(1'b1, 64'h8000000000000000, "R7");
    do_write(1'b1, 64'h100000, "R7");
    do_req(32'h5A000, "R7");
    do_req(32'h6A000, "R7");

    // R4 enable cleared
    do_write(1'b0, 64'hF0000, "R4");
    do_req(32'h50000, "R4");
    do_write(1'b0, 64'hF0800, "R4");
    do_req(32'h50000, "R4");

    // R9 lock rejects both registers
    lock_i = 1'b1;
    do_write(1'b1, 64'h20000, "R9");
    do_write(1'b0, 64'h00000, "R9");
    do_req(32'h50000, "R9");
    do_req(32'h20000, "R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule